// File: doc/BRIEF.md
# Rotate and Insert Bit-Field Unit

This unit rotates a 64-bit source word left by an immediate amount, selects a run of bit positions from the rotated word and merges them into a 64-bit destination word. The selected run is given by a start and an end position, counted from the most significant bit. When the start lies past the end, the run wraps around the edge of the active field. A zero flag chooses what happens to destination bits outside the run: they are kept, or they are cleared.

Three variants are supported. The full variant works on all 64 bits and also reports the sign of the result as a condition code. The high-half and low-half variants confine both the selection and the clearing to one 32-bit half of the word, and always pass the other half of the destination through unchanged. The rotation always acts on the full 64-bit source.

The datapath is combinational. Its result is captured in an output register on every cycle that carries an input strobe, so the answer appears one clock after the operands are presented.

Top module: `rib_unit`

## Requirements
- R1: `variant_sel` encodes 0 = full 64-bit, 1 = high half (bits 63:32), 2 = low half (bits 31:0). The full variant takes the start and end positions modulo 64 (bits 5:0 of the immediate). The half variants take them modulo 32 (bits 4:0), and ignore the higher immediate bits.
- R2: Bit 7 of `end_imm` is the zero flag and takes no part in the end position.
- R3: Positions count from the most significant bit of the active field, which is bit 63 in the full and high variants and bit 31 in the low variant. When start <= end, exactly the positions start through end inclusive are selected.
- R4: When start > end, the positions from start to the last position of the field are selected, together with the positions from 0 to end.
- R5: The source is rotated left by `rot_imm` modulo 64 (bits 5:0) across all 64 bits before any selection.
- R6: With the zero flag clear, every destination bit outside the selection keeps its value.
- R7: In the full variant with the zero flag set, every bit outside the selection is 0.
- R8: A half variant leaves the other 32-bit half equal to the destination, whatever the zero flag. With the flag set, it clears only the unselected bits inside its own half.
- R9: For the full variant, `cc_valid` is 1 and `cc` is 0 for a zero result, 1 for a negative result and 2 for a positive one, reading the result as a signed 64-bit value. For the half variants, `cc_valid` and `cc` are both 0.
- R10: `variant_sel` = 3 returns the destination unchanged, with `err` = 1 and `cc_valid` = 0. Any legal variant gives `err` = 0.
- R11: `out_valid` is 1 exactly one clock after a cycle with `in_valid` = 1. The result, `cc`, `cc_valid` and `err` then show that cycle's operation. In cycles without a strobe, the result, `cc`, `cc_valid` and `err` hold their values.
- R12: While `rst` is high at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| variant_sel | input | 2 | Variant: full, high half, low half, illegal |
| dst_in | input | 64 | Destination word |
| src_in | input | 64 | Source word to rotate |
| start_imm | input | 8 | Start position of the selected run |
| end_imm | input | 8 | Bit 7 zero flag, low bits end position |
| rot_imm | input | 8 | Left rotate amount |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Merged word |
| cc | output | 2 | Sign code of the full-variant result |
| cc_valid | output | 1 | Condition code is meaningful |
| err | output | 1 | Illegal variant code was given |

## Verification
The bench aims at the wrapped selection, at a single-bit run with start equal to end, and at a run that covers the whole field. A design that got the wrap wrong would insert the complement of the intended run or nothing at all. It also sets the high immediate bits of the start, end and rotate fields, so a unit that failed to reduce them modulo the field width would pick the wrong positions or rotate too far. Half variants are run with the zero flag set, where a unit that cleared the whole word would wipe out the preserved half. The bench also uses the illegal code, sign cases for the condition code, and idle cycles in which a unit that did not hold its result would let it drift.

// File: rtl/rib_pkg.sv
package rib_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int POS_W    = $clog2(DATA_W);
    localparam int IMM_W    = 8;
    localparam int ZERO_BIT = IMM_W - 1;

    typedef enum logic [1:0] {
        VAR_FULL = 2'd0,
        VAR_HIGH = 2'd1,
        VAR_LOW  = 2'd2,
        VAR_BAD  = 2'd3
    } variant_e;

    typedef struct packed {
        variant_e         kind;
        logic [POS_W-1:0] first;
        logic [POS_W-1:0] last;
        logic             zero;
        logic [POS_W-1:0] amount;
    } rib_ctl_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [1:0]        cc;
        logic              cc_valid;
        logic              err;
    } rib_out_t;

    // Inclusive span test on MSB-first positions, wrapping when s > e.
    function automatic logic in_span(input logic [POS_W-1:0] p,
                                     input logic [POS_W-1:0] s,
                                     input logic [POS_W-1:0] e);
        if (s <= e) return (p >= s) && (p <= e);
        else        return (p >= s) || (p <= e);
    endfunction

    // Signed classification: 0 zero, 1 negative, 2 positive.
    function automatic logic [1:0] sign_code(input logic [DATA_W-1:0] v);
        if (v == '0)           return 2'd0;
        else if (v[DATA_W-1])  return 2'd1;
        else                   return 2'd2;
    endfunction

endpackage

// File: rtl/rib_decode.sv
module rib_decode
    import rib_pkg::*;
(
    input  logic [1:0]       variant_sel,
    input  logic [IMM_W-1:0] start_imm,
    input  logic [IMM_W-1:0] end_imm,
    input  logic [IMM_W-1:0] rot_imm,
    output rib_ctl_t         ctl
);
    localparam int HPOS_W = POS_W - 1;

    always_comb begin
        ctl.kind   = variant_e'(variant_sel);
        ctl.zero   = end_imm[ZERO_BIT];
        ctl.amount = rot_imm[POS_W-1:0];
        if (ctl.kind == VAR_FULL) begin
            ctl.first = start_imm[POS_W-1:0];
            ctl.last  = end_imm[POS_W-1:0];
        end else begin
            ctl.first = {1'b0, start_imm[HPOS_W-1:0]};
            ctl.last  = {1'b0, end_imm[HPOS_W-1:0]};
        end
    end
endmodule

// File: rtl/rib_rotate.sv
module rib_rotate
    import rib_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amount,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    always_comb begin
        doubled = {din, din} << amount;
        dout    = doubled[2*W-1:W];
    end
endmodule

// File: rtl/rib_mask.sv
module rib_mask
    import rib_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = W / 2
) (
    input  rib_ctl_t     ctl,
    output logic [W-1:0] sel_mask,
    output logic [W-1:0] field_mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [POS_W-1:0] FULL_POS = POS_W'(W - 1 - i);
        localparam logic [POS_W-1:0] HALF_POS = POS_W'(HW - 1 - (i % HW));
        localparam bit               UPPER    = (i >= HW);

        logic in_field;
        logic hit;

        always_comb begin
            unique case (ctl.kind)
                VAR_FULL: in_field = 1'b1;
                VAR_HIGH: in_field = UPPER;
                VAR_LOW:  in_field = !UPPER;
                default:  in_field = 1'b0;
            endcase
            if (ctl.kind == VAR_FULL) hit = in_span(FULL_POS, ctl.first, ctl.last);
            else                      hit = in_span(HALF_POS, ctl.first, ctl.last);
        end

        assign field_mask[i] = in_field;
        assign sel_mask[i]   = in_field & hit;
    end
endmodule

// File: rtl/rib_merge.sv
module rib_merge
    import rib_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  rib_ctl_t     ctl,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] rotated,
    input  logic [W-1:0] sel_mask,
    input  logic [W-1:0] field_mask,
    output rib_out_t     res
);
    logic [W-1:0] keep_mask;
    logic [W-1:0] merged;

    always_comb begin
        // Zeroing keeps only what lies outside the active field.
        keep_mask    = ctl.zero ? ~field_mask : ~sel_mask;
        merged       = (rotated & sel_mask) | (dst & keep_mask);
        res.value    = merged;
        res.err      = (ctl.kind == VAR_BAD);
        res.cc_valid = (ctl.kind == VAR_FULL);
        res.cc       = (ctl.kind == VAR_FULL) ? sign_code(merged) : 2'd0;
    end
endmodule

// File: rtl/rib_unit.sv
module rib_unit
    import rib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        variant_sel,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic [IMM_W-1:0]  start_imm,
    input  logic [IMM_W-1:0]  end_imm,
    input  logic [IMM_W-1:0]  rot_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [1:0]        cc,
    output logic              cc_valid,
    output logic              err
);
    rib_ctl_t          ctl;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] field_mask;
    rib_out_t          comb_out;
    rib_out_t          out_q;
    logic              valid_q;

    rib_decode u_decode (
        .variant_sel (variant_sel),
        .start_imm   (start_imm),
        .end_imm     (end_imm),
        .rot_imm     (rot_imm),
        .ctl         (ctl)
    );

    rib_rotate #(.W(DATA_W)) u_rotate (
        .din    (src_in),
        .amount (ctl.amount),
        .dout   (rotated)
    );

    rib_mask #(.W(DATA_W)) u_mask (
        .ctl        (ctl),
        .sel_mask   (sel_mask),
        .field_mask (field_mask)
    );

    rib_merge #(.W(DATA_W)) u_merge (
        .ctl        (ctl),
        .dst        (dst_in),
        .rotated    (rotated),
        .sel_mask   (sel_mask),
        .field_mask (field_mask),
        .res        (comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) out_q <= comb_out;
        end
    end

    assign out_valid = valid_q;
    assign result    = out_q.value;
    assign cc        = out_q.cc;
    assign cc_valid  = out_q.cc_valid;
    assign err       = out_q.err;

    // The selection never reaches outside the active field.
    assert_mask_in_field_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_mask & ~field_mask) == '0);

    assert_strobe_latency_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(result));

    assert_high_keeps_low_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && variant_sel == VAR_HIGH) |=> result[HALF_W-1:0] == $past(dst_in[HALF_W-1:0]));

    assert_low_keeps_high_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && variant_sel == VAR_LOW) |=> result[DATA_W-1:HALF_W] == $past(dst_in[DATA_W-1:HALF_W]));

    assert_half_no_cc_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && variant_sel != VAR_FULL) |=> (!cc_valid && cc == 2'd0));

    assert_full_cc_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && variant_sel == VAR_FULL) |=> (cc_valid && cc != 2'd3));

    assert_bad_variant_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && variant_sel == VAR_BAD) |=> (err && result == $past(dst_in)));

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !err && !cc_valid));
endmodule

// File: tb/rib_unit_test.sv
`timescale 1ns/1ps
module rib_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  variant_sel = 2'd0;
    logic [63:0] dst_in = '0;
    logic [63:0] src_in = '0;
    logic [7:0]  start_imm = '0;
    logic [7:0]  end_imm = '0;
    logic [7:0]  rot_imm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  cc;
    logic        cc_valid;
    logic        err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        e_valid = 1'b0;
    logic [63:0] e_res = '0;
    logic [1:0]  e_cc = '0;
    logic        e_ccv = 1'b0;
    logic        e_err = 1'b0;
    string       e_tag = "R12";

    always #4 clk = ~clk;

    rib_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .variant_sel(variant_sel),
        .dst_in(dst_in), .src_in(src_in), .start_imm(start_imm), .end_imm(end_imm),
        .rot_imm(rot_imm), .out_valid(out_valid), .result(result), .cc(cc),
        .cc_valid(cc_valid), .err(err)
    );

    // Behavioural reference, written from the requirements.
    task automatic model(input logic [1:0] v, input logic [63:0] d, input logic [63:0] s,
                         input logic [7:0] st, input logic [7:0] en, input logic [7:0] ro,
                         output logic [63:0] r, output logic [1:0] c,
                         output logic cv, output logic er);
        logic [63:0] rot;
        int w, base, sp, ep, amt;
        bit z, sel;
        amt = int'(ro) % 64;
        for (int i = 0; i < 64; i++) rot[(i + amt) % 64] = s[i];
        r = d; c = 2'd0; cv = 1'b0; er = 1'b0;
        if (v == 2'd3) begin
            er = 1'b1;
            return;
        end
        w    = (v == 2'd0) ? 64 : 32;
        base = (v == 2'd2) ? 31 : 63;
        sp   = int'(st) % w;
        ep   = int'(en[6:0]) % w;
        z    = en[7];
        for (int p = 0; p < w; p++) begin
            if (sp <= ep) sel = (p >= sp) && (p <= ep);
            else          sel = (p >= sp) || (p <= ep);
            if (sel)    r[base - p] = rot[base - p];
            else if (z) r[base - p] = 1'b0;
        end
        if (v == 2'd0) begin
            cv = 1'b1;
            if (r == 64'd0)  c = 2'd0;
            else if (r[63])  c = 2'd1;
            else             c = 2'd2;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(out_valid === e_valid, "R11", "out_valid", 64'(out_valid), 64'(e_valid));
        check(result === e_res, e_tag, "result", result, e_res);
        check(cc === e_cc, "R9", "cc", 64'(cc), 64'(e_cc));
        check(cc_valid === e_ccv, "R9", "cc_valid", 64'(cc_valid), 64'(e_ccv));
        check(err === e_err, "R10", "err", 64'(err), 64'(e_err));
    endtask

    // One clock: check what the previous cycle produced, then drive the next.
    task automatic tick(input bit r, input bit iv, input logic [1:0] v,
                        input logic [63:0] d, input logic [63:0] s,
                        input logic [7:0] st, input logic [7:0] en,
                        input logic [7:0] ro, input string tag);
        logic [63:0] nr;
        logic [1:0]  nc;
        logic        ncv, ner;
        @(negedge clk);
        compare_outputs();
        rst = r; in_valid = iv; variant_sel = v; dst_in = d; src_in = s;
        start_imm = st; end_imm = en; rot_imm = ro;
        if (r) begin
            e_valid = 1'b0; e_res = '0; e_cc = '0; e_ccv = 1'b0; e_err = 1'b0;
            e_tag = "R12";
        end else begin
            e_valid = iv;
            if (iv) begin
                model(v, d, s, st, en, ro, nr, nc, ncv, ner);
                e_res = nr; e_cc = nc; e_ccv = ncv; e_err = ner;
                e_tag = tag;
            end else begin
                e_tag = "R11";
            end
        end
    endtask

    task automatic op(input logic [1:0] v, input logic [63:0] d, input logic [63:0] s,
                      input logic [7:0] st, input logic [7:0] en, input logic [7:0] ro,
                      input string tag);
        tick(1'b0, 1'b1, v, d, s, st, en, ro, tag);
    endtask

    task automatic idle(input string tag);
        tick(1'b0, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
             8'hFF, 8'hFF, 8'hFF, tag);
    endtask

    localparam logic [63:0] D0 = 64'hA5A5_A5A5_5A5A_5A5A;
    localparam logic [63:0] S0 = 64'h0123_4567_89AB_CDEF;

    initial begin
        // R12: reset state, driven with a strobe present
        tick(1'b1, 1'b1, 2'd0, D0, S0, 8'd0, 8'd63, 8'd0, "R12");
        tick(1'b1, 1'b1, 2'd0, D0, S0, 8'd0, 8'd63, 8'd0, "R12");
        // R3 R5 R6: contiguous run, flag clear
        op(2'd0, D0, S0, 8'd8, 8'd15, 8'd4, "R3");
        op(2'd0, D0, S0, 8'd20, 8'd20, 8'd0, "R3");
        op(2'd0, D0, S0, 8'd0, 8'd63, 8'd17, "R5");
        op(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd10, 8'd40, 8'd0, "R6");
        // R4: wrap in the full field
        op(2'd0, D0, S0, 8'd60, 8'd3, 8'd0, "R4");
        op(2'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd63, 8'd0, 8'd0, "R4");
        // R1 R5: high immediate bits ignored
        op(2'd0, D0, S0, 8'hC8, 8'h4F, 8'hC4, "R1");
        op(2'd0, D0, S0, 8'd8, 8'd15, 8'd68, "R5");
        // R2 R7: zero flag in the full variant
        op(2'd0, D0, S0, 8'd8, 8'h80 | 8'd15, 8'd4, "R7");
        op(2'd0, D0, S0, 8'd60, 8'h80 | 8'd3, 8'd9, "R2");
        op(2'd0, D0, 64'd0, 8'd0, 8'h80 | 8'd63, 8'd0, "R9");
        op(2'd0, 64'd0, 64'h8000_0000_0000_0000, 8'd0, 8'h80, 8'd0, "R9");
        op(2'd0, 64'd0, 64'h0000_0000_0000_0001, 8'd63, 8'h80 | 8'd63, 8'd0, "R9");
        // R8 R1: half variants, flag clear and set, wraps and modulo 32
        op(2'd1, D0, S0, 8'd4, 8'd11, 8'd32, "R8");
        op(2'd1, D0, S0, 8'd28, 8'h80 | 8'd3, 8'd5, "R8");
        op(2'd2, D0, S0, 8'd0, 8'h80 | 8'd31, 8'd0, "R8");
        op(2'd2, D0, S0, 8'd30, 8'd1, 8'd40, "R4");
        op(2'd2, D0, S0, 8'h48, 8'h6F, 8'd3, "R1");
        op(2'd1, D0, S0, 8'hE2, 8'h80 | 8'h3A, 8'd1, "R1");
        // R10: illegal variant
        op(2'd3, D0, S0, 8'd0, 8'h80 | 8'd63, 8'd0, "R10");
        // R11: idle cycles hold, then back-to-back strobes
        idle("R11");
        idle("R11");
        op(2'd0, D0, S0, 8'd1, 8'd2, 8'd3, "R11");
        op(2'd1, S0, D0, 8'd5, 8'd6, 8'd7, "R11");
        idle("R11");
        // mixed vectors over all variants and immediates
        for (int k = 0; k < 400; k++) begin
            op(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
               8'($urandom), 8'($urandom), 8'($urandom), "R4");
            if (k % 37 == 0) idle("R11");
        end
        // R12: reset in the middle of a run
        tick(1'b1, 1'b1, 2'd0, D0, S0, 8'd0, 8'd63, 8'd0, "R12");
        tick(1'b0, 1'b0, 2'd0, D0, S0, 8'd0, 8'd63, 8'd0, "R12");
        idle("R11");
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule